// File: doc/BRIEF.md
# Framed Synchronous Serial Transceiver

This block moves parallel words over a full-duplex synchronous serial link. On the transmit side a word is accepted through a valid/ready handshake and held in a single holding register. It is shifted out most significant bit first on `sdata_o`, framed by `fsync_o`. On the receive side `sdata_i` is sampled under `fsync_i`, and each completed word is presented on `rx_data_o` with a valid/ready handshake. One-cycle event strobes mark each word entering the transmit shifter and each word completed by the receiver.

Packets are 8, 10, 12 or 16 bits long. In burst framing every packet gets its own one-bit frame pulse. In continuous framing one pulse starts a stream of back-to-back packets. The bit clock is either divided down from the system clock or taken from `sclk_ext_i`. The clock and frame polarities are set by configuration pins. All logic runs on the system clock, so any bit rate down to zero is handled.

Top module: `sync_serial_xcvr`

## Requirements
- R1: `len_sel_i` selects the packet length: 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 16. Only the low packet-length bits of `tx_data_i` are sent, MSB first. The received word appears right-aligned and zero-extended on `rx_data_o`.
- R2: With `cont_i`=0 (burst), every packet is preceded by a frame pulse lasting exactly one bit period. The pulse sits in the bit period just before the MSB, and `sdata_o` is 0 while the pulse is active.
- R3: With `cont_i`=1 (continuous), a frame pulse is sent only before the first word. Later words that are already held when the previous packet ends follow with no pulse and no gap.
- R4: In continuous framing, if no word is held when a packet ends, `tx_urun_o` pulses for one cycle and the line goes idle. The next word is sent with a fresh frame pulse. While the transmitter is idle, `tx_urun_o` stays low.
- R5: With `fs_pol_i`=0 the frame strobe is active high. With `fs_pol_i`=1 it is active low and idles high. The receiver interprets `fsync_i` with the same polarity.
- R6: With the internal clock, one bit period lasts `div_i`+1 system clocks. At `div_i`=0 there is one bit per system clock, and `sclk_o` is held at its idle level (`clk_pol_i`). For `div_i`>0, `sclk_o` has a period of `div_i`+1 clocks.
- R7: With `ext_clk_i`=1, bits move only on edges of `sclk_ext_i`. With `clk_pol_i`=0 the transmitter drives on rising edges and the receiver samples on falling edges; `clk_pol_i`=1 swaps the edges. A stopped external clock moves no data.
- R8: The transmitter holds one word: `tx_ready_o` is low while a word is held. `tx_evt_o` pulses for one cycle each time a held word enters the shifter, and at that point `tx_ready_o` is high again.
- R9: `rx_evt_o` pulses for one cycle per completed word. `rx_valid_o` then stays high, with the data stable, until `rx_ready_i` is seen high.
- R10: During reset, `sdata_o` is 0, `fsync_o` is at its inactive level, `tx_ready_o` is 1, and `rx_valid_o`, `tx_evt_o`, `rx_evt_o` and `tx_urun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| len_sel_i | input | 2 | Packet length code |
| cont_i | input | 1 | 1 = continuous framing, 0 = burst |
| fs_pol_i | input | 1 | 1 = frame strobe active low |
| clk_pol_i | input | 1 | Bit clock polarity / edge swap |
| ext_clk_i | input | 1 | 1 = use sclk_ext_i as bit clock |
| div_i | input | DIV_W | Internal bit period minus one, in system clocks |
| sclk_ext_i | input | 1 | External bit clock |
| tx_data_i | input | 16 | Word to transmit |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Holding register free |
| rx_data_o | output | 16 | Received word, right-aligned |
| rx_valid_o | output | 1 | Received word valid |
| rx_ready_i | input | 1 | Consumer accepts received word |
| sclk_o | output | 1 | Internally generated bit clock |
| sdata_o | output | 1 | Serial transmit data |
| fsync_o | output | 1 | Transmit frame strobe |
| sdata_i | input | 1 | Serial receive data |
| fsync_i | input | 1 | Receive frame strobe |
| tx_evt_o | output | 1 | Word loaded into transmit shifter |
| rx_evt_o | output | 1 | Receive word completed |
| tx_urun_o | output | 1 | Continuous-mode transmit underflow |

## Verification
The bench builds the block with its default `DIV_W` of 8 and loops the serial data and frame pins back onto the receive side. This lets one instance check both directions. At run time it sweeps `div_i` from 0 to 4, which covers the single-clock bit rate where launch and sample share every cycle as well as divided rates with a mid-period sample. The sweep also covers every packet-length code, both framings and both polarities. A separately toggled external clock, stopped and running in both edge orders, reaches the edge-detect path that the internal divider never uses.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 5;

  typedef enum logic {ST_IDLE, ST_DATA} ser_st_e;

  function automatic logic [LEN_W-1:0] pkt_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return LEN_W'(8);
      2'd1:    return LEN_W'(10);
      2'd2:    return LEN_W'(12);
      default: return LEN_W'(16);
    endcase
  endfunction

  // place the packet MSB at the top of the shifter
  function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] w,
                                                   input logic [1:0] sel);
    case (sel)
      2'd0:    return {w[7:0], 8'h00};
      2'd1:    return {w[9:0], 6'h00};
      2'd2:    return {w[11:0], 4'h0};
      default: return w;
    endcase
  endfunction
endpackage

// File: rtl/ssx_bitclk.sv
module ssx_bitclk #(
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_sel_i,
  input  logic             clk_pol_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sclk_ext_i,
  output logic             launch_o,
  output logic             sample_o,
  output logic             sclk_o
);
  localparam int SR_W = SYNC_N + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   per, half, cnt_x;
  logic [SR_W-1:0]  sync_q;
  logic             lvl_now, lvl_prev, int_launch, int_sample;

  assign per   = {1'b0, div_i} + 1'b1;
  assign half  = per >> 1;
  assign cnt_x = {1'b0, cnt_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_q <= '0;
    end else begin
      cnt_q  <= (cnt_q >= div_i) ? '0 : cnt_q + 1'b1;
      sync_q <= {sync_q[SR_W-2:0], sclk_ext_i};
    end
  end

  assign int_launch = (cnt_q == '0);
  assign int_sample = (cnt_x == half);
  assign lvl_now    = sync_q[SR_W-2] ^ clk_pol_i;
  assign lvl_prev   = sync_q[SR_W-1] ^ clk_pol_i;

  assign launch_o = ext_sel_i ? (lvl_now & ~lvl_prev) : int_launch;
  assign sample_o = ext_sel_i ? (~lvl_now & lvl_prev) : int_sample;
  assign sclk_o   = ((div_i != '0) && (cnt_x < half)) ^ clk_pol_i;
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx
  import ssx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [1:0]        len_sel_i,
  input  logic              cont_i,
  input  logic              fs_pol_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              sdata_o,
  output logic              fsync_o,
  output logic              tx_evt_o,
  output logic              tx_urun_o
);
  ser_st_e           st_q;
  logic [WORD_W-1:0] hold_q, sh_q, aligned;
  logic [LEN_W-1:0]  left_q, len;
  logic              hold_full_q, sd_q, fs_q, evt_q, urun_q;
  logic              done, load, cont_load, pulse_load;

  assign len        = pkt_len(len_sel_i);
  assign aligned    = left_align(hold_q, len_sel_i);
  assign done       = (st_q == ST_DATA) && (left_q == '0);
  assign load       = launch_i && hold_full_q && ((st_q == ST_IDLE) || done);
  assign cont_load  = load && done && cont_i;
  assign pulse_load = load && !cont_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      sh_q        <= '0;
      left_q      <= '0;
      sd_q        <= 1'b0;
      fs_q        <= 1'b0;
      evt_q       <= 1'b0;
      urun_q      <= 1'b0;
    end else begin
      if (tx_valid_i && !hold_full_q) begin
        hold_q      <= tx_data_i;
        hold_full_q <= 1'b1;
      end else if (load) begin
        hold_full_q <= 1'b0;
      end
      evt_q  <= load;
      urun_q <= launch_i && done && cont_i && !hold_full_q;
      if (launch_i) begin
        fs_q <= pulse_load;
        if (cont_load) begin
          sd_q   <= aligned[WORD_W-1];
          sh_q   <= {aligned[WORD_W-2:0], 1'b0};
          left_q <= len - 1'b1;
          st_q   <= ST_DATA;
        end else if (pulse_load) begin
          sd_q   <= 1'b0;
          sh_q   <= aligned;
          left_q <= len;
          st_q   <= ST_DATA;
        end else if ((st_q == ST_DATA) && !done) begin
          sd_q   <= sh_q[WORD_W-1];
          sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
          left_q <= left_q - 1'b1;
        end else begin
          sd_q <= 1'b0;
          st_q <= ST_IDLE;
        end
      end
    end
  end

  assign tx_ready_o = !hold_full_q;
  assign sdata_o    = sd_q;
  assign fsync_o    = fs_q ^ fs_pol_i;
  assign tx_evt_o   = evt_q;
  assign tx_urun_o  = urun_q;
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx
  import ssx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [1:0]        len_sel_i,
  input  logic              cont_i,
  input  logic              fs_pol_i,
  input  logic              sdata_i,
  input  logic              fsync_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              rx_evt_o
);
  ser_st_e           st_q;
  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] data_q;
  logic [LEN_W-1:0]  left_q, len;
  logic              fs_act, word_done, valid_q, evt_q;

  assign len       = pkt_len(len_sel_i);
  assign fs_act    = fsync_i ^ fs_pol_i;
  assign word_done = sample_i && !fs_act && (st_q == ST_DATA) && (left_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= word_done;
      if (word_done) begin
        data_q  <= {sh_q, sdata_i};
        valid_q <= 1'b1;
      end else if (rx_ready_i) begin
        valid_q <= 1'b0;
      end
      if (sample_i) begin
        if (fs_act) begin
          st_q   <= ST_DATA;
          left_q <= len;
          sh_q   <= '0;
        end else if (st_q == ST_DATA) begin
          if (word_done) begin
            sh_q   <= '0;
            left_q <= len;
            if (!cont_i) st_q <= ST_IDLE;
          end else begin
            sh_q   <= {sh_q[WORD_W-3:0], sdata_i};
            left_q <= left_q - 1'b1;
          end
        end
      end
    end
  end

  assign rx_data_o  = data_q;
  assign rx_valid_o = valid_q;
  assign rx_evt_o   = evt_q;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        len_sel_i,
  input  logic              cont_i,
  input  logic              fs_pol_i,
  input  logic              clk_pol_i,
  input  logic              ext_clk_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              sclk_ext_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              fsync_o,
  input  logic              sdata_i,
  input  logic              fsync_i,
  output logic              tx_evt_o,
  output logic              rx_evt_o,
  output logic              tx_urun_o
);
  logic launch, sample;

  ssx_bitclk #(.DIV_W(DIV_W), .SYNC_N(2)) u_bitclk (
    .clk_i, .rst_ni,
    .ext_sel_i (ext_clk_i),
    .clk_pol_i, .div_i, .sclk_ext_i,
    .launch_o  (launch),
    .sample_o  (sample),
    .sclk_o
  );

  ssx_tx u_tx (
    .clk_i, .rst_ni,
    .launch_i (launch),
    .len_sel_i, .cont_i, .fs_pol_i,
    .tx_data_i, .tx_valid_i, .tx_ready_o,
    .sdata_o, .fsync_o, .tx_evt_o, .tx_urun_o
  );

  ssx_rx u_rx (
    .clk_i, .rst_ni,
    .sample_i (sample),
    .len_sel_i, .cont_i, .fs_pol_i,
    .sdata_i, .fsync_i,
    .rx_data_o, .rx_valid_o, .rx_ready_i, .rx_evt_o
  );
endmodule

// File: rtl/ssx_chk.sv
module ssx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cont_i,
  input logic fs_pol_i,
  input logic fsync_o,
  input logic sdata_o,
  input logic tx_ready_o,
  input logic tx_evt_o,
  input logic tx_urun_o,
  input logic rx_valid_o,
  input logic rx_ready_i
);
  // R2
  fs_bit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_o != fs_pol_i) |-> (sdata_o == 1'b0));

  // R8
  tx_evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_evt_o |=> !tx_evt_o);

  // R8
  tx_evt_frees_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_evt_o |-> tx_ready_o);

  // R4
  urun_cont_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_urun_o |-> $past(cont_i));

  // R4
  urun_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_urun_o |-> !tx_evt_o);

  // R9
  rx_valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o);
endmodule

bind sync_serial_xcvr ssx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cont_i     (cont_i),
  .fs_pol_i   (fs_pol_i),
  .fsync_o    (fsync_o),
  .sdata_o    (sdata_o),
  .tx_ready_o (tx_ready_o),
  .tx_evt_o   (tx_evt_o),
  .tx_urun_o  (tx_urun_o),
  .rx_valid_o (rx_valid_o),
  .rx_ready_i (rx_ready_i)
);

// File: tb/sync_serial_xcvr_test.sv
module sync_serial_xcvr_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  len_sel = 2'd0;
  logic        cont = 1'b0, fs_pol = 1'b0, clk_pol = 1'b0, ext_clk = 1'b0;
  logic [7:0]  div = 8'd1;
  logic        sclk_ext = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0, rx_ready = 1'b1;
  logic        tx_ready, rx_valid, sclk, sdata, fsync, tx_evt, rx_evt, tx_urun;
  logic [15:0] rx_data;

  int checks = 0, errors = 0;
  int rx_cnt = 0, tx_evt_n = 0, rx_evt_n = 0, urun_n = 0, fs_n = 0, fs_cyc = 0;
  logic fs_prev = 1'b0;
  logic [15:0] rx_buf [64];
  logic ext_run = 1'b0;

  always #10 clk = ~clk;

  sync_serial_xcvr #(.DIV_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .len_sel_i(len_sel), .cont_i(cont),
    .fs_pol_i(fs_pol), .clk_pol_i(clk_pol), .ext_clk_i(ext_clk), .div_i(div),
    .sclk_ext_i(sclk_ext), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .sclk_o(sclk), .sdata_o(sdata), .fsync_o(fsync),
    .sdata_i(sdata), .fsync_i(fsync), .tx_evt_o(tx_evt), .rx_evt_o(rx_evt),
    .tx_urun_o(tx_urun)
  );

  typedef struct packed {
    logic [1:0]  len;
    logic        cont, fsp, ckp;
    logic [7:0]  div;
    logic [15:0] w0, w1, e0, e1;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 8'd1, 16'h00A5, 16'h003C, 16'h00A5, 16'h003C},
    '{2'd1, 1'b0, 1'b1, 1'b0, 8'd2, 16'h02F1, 16'h010F, 16'h02F1, 16'h010F},
    '{2'd2, 1'b1, 1'b0, 1'b0, 8'd3, 16'h0ABC, 16'h05A3, 16'h0ABC, 16'h05A3},
    '{2'd3, 1'b1, 1'b1, 1'b1, 8'd0, 16'hBEEF, 16'h8001, 16'hBEEF, 16'h8001},
    '{2'd3, 1'b0, 1'b0, 1'b0, 8'd0, 16'h1234, 16'hFFFF, 16'h1234, 16'hFFFF},
    '{2'd0, 1'b1, 1'b0, 1'b1, 8'd4, 16'hFF81, 16'hC37E, 16'h0081, 16'h007E}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitors, sampled away from the active edge
  initial forever begin
    @(negedge clk);
    if (rx_valid && rx_ready) begin
      if (rx_cnt < 64) rx_buf[rx_cnt] = rx_data;
      rx_cnt++;
    end
    if (tx_evt) tx_evt_n++;
    if (rx_evt) rx_evt_n++;
    if (tx_urun) urun_n++;
    if (fsync ^ fs_pol) fs_cyc++;
    if ((fsync ^ fs_pol) && !fs_prev) fs_n++;
    fs_prev = fsync ^ fs_pol;
  end

  // external bit clock source
  initial begin
    int ext_div = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ext_div++;
        if (ext_div == 5) begin sclk_ext = ~sclk_ext; ext_div = 0; end
      end else begin
        sclk_ext = 1'b0;
        ext_div  = 0;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rx_cnt = 0; tx_evt_n = 0; rx_evt_n = 0; urun_n = 0; fs_n = 0; fs_cyc = 0;
    fs_prev = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    int t = 0;
    while (rx_cnt < n && t < 5000) begin @(negedge clk); t++; end
  endtask

  function automatic logic found_in_buf(input logic [15:0] w);
    for (int k = 0; k < 64; k++)
      if (k < rx_cnt && rx_buf[k] == w) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual 200000 cycles expected fewer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10 / R5: reset levels with an active-low frame strobe
    fs_pol = 1'b1; div = 8'd3;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "sdata in reset", 32'(sdata), 32'd0);
    chk("R5", "fsync idle level active-low", 32'(fsync), 32'd1);
    chk("R10", "tx_ready in reset", 32'(tx_ready), 32'd1);
    chk("R10", "rx_valid in reset", 32'(rx_valid), 32'd0);
    chk("R10", "events in reset", 32'({tx_evt, rx_evt, tx_urun}), 32'd0);

    // R6: sclk period for div 3
    fs_pol = 1'b0;
    do_reset();
    begin
      int per = 0;
      while (sclk) @(negedge clk);
      while (!sclk) @(negedge clk);
      @(negedge clk); per = 1;
      while (sclk) begin @(negedge clk); per++; end
      while (!sclk) begin @(negedge clk); per++; end
      chk("R6", "sclk period div3", 32'(per), 32'd4);
    end

    // table-driven loopback sweep
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      string rq = v.fsp ? "R5" : "R1";
      len_sel = v.len; cont = v.cont; fs_pol = v.fsp; clk_pol = v.ckp; div = v.div;
      do_reset();
      send(v.w0);
      send(v.w1);
      wait_rx(2);
      repeat ((32'(v.div) + 1) * 24) @(negedge clk);
      chk(rq, "rx word 0", 32'(rx_buf[0]), 32'(v.e0));
      chk(rq, "rx word 1", 32'(rx_buf[1]), 32'(v.e1));
      if (v.cont) begin
        chk("R3", "continuous frame pulses", 32'(fs_n), 32'd1);
        chk("R4", "underflow after stream", 32'(urun_n), 32'd1);
      end else begin
        chk("R2", "burst frame pulses", 32'(fs_n), 32'd2);
        chk("R4", "no underflow in burst", 32'(urun_n), 32'd0);
      end
      chk("R6", "frame pulse width", 32'(fs_cyc), 32'(fs_n * (32'(v.div) + 1)));
      chk("R8", "tx load events", 32'(tx_evt_n), 32'd2);
    end

    // R7: external clock, stopped then running, both edge orders
    ext_clk = 1'b1; cont = 1'b0; len_sel = 2'd0; fs_pol = 1'b0; clk_pol = 1'b0;
    do_reset();
    send(16'h00D2);
    repeat (300) @(negedge clk);
    chk("R7", "stopped ext clock loads nothing", 32'(tx_evt_n), 32'd0);
    chk("R7", "stopped ext clock no frame", 32'(fs_n), 32'd0);
    chk("R8", "ready low while word held", 32'(tx_ready), 32'd0);
    ext_run = 1'b1;
    wait_rx(1);
    chk("R7", "ext clock rising-launch word", 32'(rx_buf[0]), 32'h00D2);
    ext_run = 1'b0;
    repeat (10) @(negedge clk);
    clk_pol = 1'b1;
    do_reset();
    send(16'h0096);
    ext_run = 1'b1;
    wait_rx(1);
    chk("R7", "ext clock falling-launch word", 32'(rx_buf[0]), 32'h0096);
    ext_run = 1'b0;
    repeat (10) @(negedge clk);
    ext_clk = 1'b0; clk_pol = 1'b0;

    // R4: continuous underflow then restart with a new pulse
    cont = 1'b1; len_sel = 2'd0; div = 8'd1;
    do_reset();
    send(16'h005A);
    begin
      int t = 0;
      while (urun_n < 1 && t < 2000) begin @(negedge clk); t++; end
    end
    chk("R4", "underflow pulse count", 32'(urun_n), 32'd1);
    repeat (40) @(negedge clk);
    chk("R4", "no repeat underflow while idle", 32'(urun_n), 32'd1);
    send(16'h00C3);
    begin
      int t = 0;
      while (tx_evt_n < 2 && t < 2000) begin @(negedge clk); t++; end
    end
    repeat (60) @(negedge clk);
    chk("R4", "new frame pulse after underflow", 32'(fs_n), 32'd2);
    chk("R4", "word after underflow received", 32'(found_in_buf(16'h00C3)), 32'd1);

    // R9: receive hold under back-pressure
    cont = 1'b0; len_sel = 2'd3; div = 8'd0; rx_ready = 1'b0;
    do_reset();
    send(16'h4D2B);
    begin
      int t = 0;
      while (rx_evt_n < 1 && t < 2000) begin @(negedge clk); t++; end
    end
    repeat (10) @(negedge clk);
    chk("R9", "valid held without ready", 32'(rx_valid), 32'd1);
    chk("R9", "data held without ready", 32'(rx_data), 32'h4D2B);
    chk("R9", "one rx event", 32'(rx_evt_n), 32'd1);
    rx_ready = 1'b1;
    @(negedge clk);
    chk("R9", "valid drops after accept", 32'(rx_valid), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule